// File: doc/BRIEF.md
# Serial Table-Read Programming Master

This block is the host side of a two-wire serial programming link. It reads a target's nonvolatile memory one byte at a time. A request gives a 22-bit start address and a byte count. The engine first loads the target's three-byte table pointer by injecting six core-instruction frames. It then repeats a table-read-with-post-increment frame once per byte. Each received byte is returned on a valid/ready response port.

The block owns the serial clock line and drives the bidirectional data line through a separate output enable. It releases the data line for a timed turnaround in the middle of every read frame. Every frame is a 4-bit command code followed by 16 operand clocks, and all bits travel least significant bit first. The clock high and low periods, the turnaround delay and the delay between frames are all parameters counted in system clocks.

The engine keeps a 22-bit shadow of the target pointer. It rejects a request that would read past the top of the 0x000000..0x3FFFFF space. The address is loaded only once per request, because the target advances its own pointer after each byte.

Top module: `tblrd_host`

## Requirements
- R1: An accepted request with a nonzero count starts with six frames that use command code 4'b0000. Their 16-bit payloads are, in this order: {0x0E, 2'b00, addr[21:16]}, 0x6EF8, {0x0E, addr[15:8]}, 0x6EF7, {0x0E, addr[7:0]}, 0x6EF6.
- R2: Each address-load frame carries 20 bits on the data line, with the output enable high at every bit. The 4-bit code comes first and the 16-bit payload follows it, each least significant bit first.
- R3: Each byte is fetched with a frame whose code is 4'b1001. The host drives 8 zero operand bits, then samples 8 bits that the target drives, least significant bit first. The byte assembled this way is returned on rsp_data_o.
- R4: After the falling edge of the 8th operand clock of a read frame, the host holds pgd_oe_o low for all 8 read bits. The clock stays low for at least TURN_CYC system clocks before the first read bit.
- R5: Each clock high phase lasts HALF_CYC system clocks. The data output changes only together with a rising clock edge.
- R6: A request for N bytes produces exactly N read frames and exactly one address load. Byte i equals the target content at address addr+i.
- R7: The engine rejects a request when addr+count exceeds 0x400000. It consumes the request and pulses err_o for one cycle. It issues no clock pulse and no response for that request.
- R8: A request with count 0 is consumed with no frame, no response and no error.
- R9: After any frame ends, at least GAP_CYC system clocks pass between its last falling clock edge and the first rising edge of the next frame.
- R10: While rsp_valid_o is high and rsp_ready_i is low, rsp_data_o holds its value and no further frame is started.
- R11: req_ready_o is high only when the engine is idle. While it is high, the clock is low, the data line is released and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Engine idle, request taken |
| req_addr_i | input | 22 | Start address |
| req_count_i | input | CNT_W | Number of bytes to read |
| err_o | output | 1 | One-cycle pulse on a range-rejected request |
| rsp_valid_o | output | 1 | Read byte valid |
| rsp_ready_i | input | 1 | Consumer accepts byte |
| rsp_data_o | output | 8 | Read byte |
| pgc_o | output | 1 | Serial clock to target |
| pgd_o | output | 1 | Serial data driven to target |
| pgd_oe_o | output | 1 | Data line output enable |
| pgd_i | input | 1 | Serial data from target |

## Verification
The bench models the target behaviourally. It decodes frames at falling clock edges, rebuilds the table pointer from the injected instructions and drives read bits on rising edges. A design that skips the turnaround wait or keeps driving during read bits is caught by the turnaround timing and output-enable checks. A design that drops the inter-frame gap fails the gap measurement. Range checks hit the exact top of the space: reading the last two bytes must succeed, while one byte more must raise err_o and produce no clock. A response that is held off by the consumer must keep its data and must not start a new frame. A design that samples on the wrong edge returns a shifted byte.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;
  localparam int unsigned ADDR_W  = 22;
  localparam int unsigned FRAME_W = 20;
  localparam logic [3:0]  CMD_CORE      = 4'b0000;
  localparam logic [3:0]  CMD_TBLRD_INC = 4'b1001;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CORE, ST_GAP, ST_RDCMD, ST_TURN, ST_RDDAT, ST_HOLD
  } seq_state_e;

  typedef enum logic [1:0] {PH_IDLE, PH_HIGH, PH_LOW} phy_state_e;

  // payload of the idx-th pointer-load instruction
  function automatic logic [15:0] core_word(input logic [2:0] idx, input logic [ADDR_W-1:0] a);
    logic [15:0] w;
    case (idx)
      3'd0:    w = {8'h0E, 2'b00, a[21:16]};
      3'd1:    w = 16'h6EF8;
      3'd2:    w = {8'h0E, a[15:8]};
      3'd3:    w = 16'h6EF7;
      3'd4:    w = {8'h0E, a[7:0]};
      default: w = 16'h6EF6;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/tblrd_timer.sv
module tblrd_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= len_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/tblrd_phy.sv
module tblrd_phy import tblrd_pkg::*; #(
  parameter int unsigned HALF_CYC = 4,
  parameter int unsigned TMR_W    = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [4:0]         nbits_i,
  input  logic [FRAME_W-1:0] tx_i,
  input  logic               rx_i,
  input  logic               pgd_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [7:0]         rx_byte_o,
  output logic               pgc_o,
  output logic               pgd_o,
  output logic               pgd_oe_o
);
  localparam logic [TMR_W-1:0] HALF_LEN = TMR_W'(HALF_CYC - 1);

  phy_state_e         st_q;
  logic [FRAME_W-1:0] sh_q;
  logic [4:0]         left_q;
  logic               rx_q, pgc_q, pgd_q, done_q;
  logic [7:0]         rxsh_q;
  logic               tmr_load, tmr_zero;

  always_comb begin
    tmr_load = 1'b0;
    case (st_q)
      PH_IDLE: tmr_load = start_i;
      PH_HIGH: tmr_load = tmr_zero;
      PH_LOW:  tmr_load = tmr_zero && (left_q != 5'd1);
      default: tmr_load = 1'b0;
    endcase
  end

  tblrd_timer #(.W(TMR_W)) u_half (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .len_i(HALF_LEN), .zero_o(tmr_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= PH_IDLE; sh_q <= '0; left_q <= '0; rx_q <= 1'b0;
      pgc_q <= 1'b0; pgd_q <= 1'b0; done_q <= 1'b0; rxsh_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        PH_IDLE: if (start_i) begin
          sh_q <= tx_i; left_q <= nbits_i; rx_q <= rx_i;
          pgc_q <= 1'b1; pgd_q <= tx_i[0]; st_q <= PH_HIGH;
        end
        PH_HIGH: if (tmr_zero) begin
          pgc_q <= 1'b0;                                 // sample at falling edge
          if (rx_q) rxsh_q <= {pgd_i, rxsh_q[7:1]};
          st_q <= PH_LOW;
        end
        PH_LOW: if (tmr_zero) begin
          if (left_q == 5'd1) begin
            st_q <= PH_IDLE; done_q <= 1'b1;
          end else begin
            left_q <= left_q - 1'b1;
            sh_q   <= sh_q >> 1;
            pgd_q  <= sh_q[1];                           // change at rising edge
            pgc_q  <= 1'b1;
            st_q   <= PH_HIGH;
          end
        end
        default: st_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o    = (st_q != PH_IDLE);
  assign done_o    = done_q;
  assign rx_byte_o = rxsh_q;
  assign pgc_o     = pgc_q;
  assign pgd_o     = pgd_q;
  assign pgd_oe_o  = busy_o && !rx_q;
endmodule

// File: rtl/tblrd_host.sv
module tblrd_host import tblrd_pkg::*; #(
  parameter int unsigned HALF_CYC = 4,
  parameter int unsigned TURN_CYC = 40,
  parameter int unsigned GAP_CYC  = 8,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned TMR_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [CNT_W-1:0]  req_count_i,
  output logic              err_o,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [7:0]        rsp_data_o,
  output logic              pgc_o,
  output logic              pgd_o,
  output logic              pgd_oe_o,
  input  logic              pgd_i
);
  localparam int unsigned      SUM_W    = ((CNT_W > ADDR_W) ? CNT_W : ADDR_W) + 1;
  localparam logic [SUM_W-1:0] ADDR_END = SUM_W'(1) << ADDR_W;
  localparam logic [TMR_W-1:0] TURN_LEN = TMR_W'(TURN_CYC - 1);
  localparam logic [TMR_W-1:0] GAP_LEN  = TMR_W'(GAP_CYC - 1);

  seq_state_e         state_q, nxt_q;
  logic [2:0]         idx_q;
  logic [ADDR_W:0]    addr_q;
  logic [CNT_W-1:0]   left_q;
  logic [7:0]         data_q;
  logic               err_q, fired_q;

  logic               phy_start, phy_busy, phy_done, phy_rx;
  logic [4:0]         phy_nbits;
  logic [FRAME_W-1:0] phy_tx;
  logic [7:0]         phy_byte;
  logic               wt_load, wt_zero;
  logic [TMR_W-1:0]   wt_len;
  logic [SUM_W-1:0]   end_sum;
  logic               overrun;

  assign end_sum = SUM_W'(req_addr_i) + SUM_W'(req_count_i);
  assign overrun = end_sum > ADDR_END;

  always_comb begin
    phy_tx    = '0;
    phy_nbits = 5'd20;
    phy_rx    = 1'b0;
    case (state_q)
      ST_CORE:  phy_tx = {core_word(idx_q, addr_q[ADDR_W-1:0]), CMD_CORE};
      ST_RDCMD: begin phy_tx = FRAME_W'({8'h00, CMD_TBLRD_INC}); phy_nbits = 5'd12; end
      ST_RDDAT: begin phy_nbits = 5'd8; phy_rx = 1'b1; end
      default:  ;
    endcase
  end

  assign phy_start = (state_q == ST_CORE || state_q == ST_RDCMD || state_q == ST_RDDAT)
                     && !fired_q && !phy_busy;
  assign wt_load = ((state_q == ST_CORE || state_q == ST_RDCMD) && phy_done)
                || (state_q == ST_HOLD && rsp_ready_i && left_q != '0);
  assign wt_len  = (state_q == ST_RDCMD) ? TURN_LEN : GAP_LEN;

  tblrd_phy #(.HALF_CYC(HALF_CYC), .TMR_W(TMR_W)) u_phy (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(phy_start), .nbits_i(phy_nbits),
    .tx_i(phy_tx), .rx_i(phy_rx), .pgd_i(pgd_i), .busy_o(phy_busy), .done_o(phy_done),
    .rx_byte_o(phy_byte), .pgc_o(pgc_o), .pgd_o(pgd_o), .pgd_oe_o(pgd_oe_o)
  );

  tblrd_timer #(.W(TMR_W)) u_wait (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(wt_load), .len_i(wt_len), .zero_o(wt_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; nxt_q <= ST_IDLE; idx_q <= '0; addr_q <= '0;
      left_q <= '0; data_q <= '0; err_q <= 1'b0; fired_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (phy_start)     fired_q <= 1'b1;
      else if (phy_done) fired_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          if (overrun) err_q <= 1'b1;
          else if (req_count_i != '0) begin
            addr_q  <= {1'b0, req_addr_i};
            left_q  <= req_count_i;
            idx_q   <= '0;
            state_q <= ST_CORE;
          end
        end
        ST_CORE: if (phy_done) begin
          nxt_q   <= (idx_q == 3'd5) ? ST_RDCMD : ST_CORE;
          idx_q   <= idx_q + 1'b1;
          state_q <= ST_GAP;
        end
        ST_GAP:   if (wt_zero) state_q <= nxt_q;
        ST_RDCMD: if (phy_done) state_q <= ST_TURN;
        ST_TURN:  if (wt_zero) state_q <= ST_RDDAT;
        ST_RDDAT: if (phy_done) begin
          data_q  <= phy_byte;
          addr_q  <= addr_q + 1'b1;
          left_q  <= left_q - 1'b1;
          state_q <= ST_HOLD;
        end
        ST_HOLD: if (rsp_ready_i) begin
          if (left_q == '0) state_q <= ST_IDLE;
          else begin nxt_q <= ST_RDCMD; state_q <= ST_GAP; end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = (state_q == ST_HOLD);
  assign rsp_data_o  = data_q;
  assign err_o       = err_q;
endmodule

// File: rtl/tblrd_host_chk.sv
module tblrd_host_chk import tblrd_pkg::*; (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic            err_o,
  input logic            rsp_valid_o,
  input logic            rsp_ready_i,
  input logic [7:0]      rsp_data_o,
  input logic            pgc_o,
  input logic            pgd_o,
  input logic            pgd_oe_o,
  input seq_state_e      state_q,
  input logic [ADDR_W:0] addr_q
);
  AST_RSP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_data_o)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !pgc_o && !pgd_oe_o && !rsp_valid_o); // R11
  AST_ERR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> req_ready_o && !pgc_o); // R7
  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(req_valid_i && req_ready_o)); // R7
  AST_DATA_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pgd_o) |-> $rose(pgc_o)); // R5
  AST_TURN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_TURN |-> !pgc_o && !pgd_oe_o); // R4
  AST_RX_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RDDAT |-> !pgd_oe_o); // R4
  AST_ADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_q <= 23'h400000); // R6
endmodule

bind tblrd_host tblrd_host_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .err_o(err_o), .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i),
  .rsp_data_o(rsp_data_o), .pgc_o(pgc_o), .pgd_o(pgd_o), .pgd_oe_o(pgd_oe_o),
  .state_q(state_q), .addr_q(addr_q)
);

// File: tb/tblrd_host_tb_top.sv
module tblrd_host_tb_top;
  localparam int HALF = 2;
  localparam int TURN = 12;
  localparam int GAP  = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [21:0] req_addr = '0;
  logic [15:0] req_count = '0;
  logic        rsp_ready = 1'b1;
  logic        pgd_in = 1'b1;
  logic        req_ready, err, rsp_valid, pgc, pgd, pgd_oe;
  logic [7:0]  rsp_data;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tblrd_host #(.HALF_CYC(HALF), .TURN_CYC(TURN), .GAP_CYC(GAP), .CNT_W(16), .TMR_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_count_i(req_count), .err_o(err), .rsp_valid_o(rsp_valid),
    .rsp_ready_i(rsp_ready), .rsp_data_o(rsp_data), .pgc_o(pgc), .pgd_o(pgd),
    .pgd_oe_o(pgd_oe), .pgd_i(pgd_in)
  );

  function automatic logic [7:0] mem_byte(input logic [21:0] a);
    return a[7:0] ^ {a[13:8], a[21:20]} ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural target
  int          cyc = 0;
  int          t_rise = 0, t_fall = 0, bitn = 0;
  int          n_frames = 0, core_cnt = 0, n_reads = 0;
  logic [3:0]  cmd = '0;
  logic [15:0] pay = '0, core_log [6];
  logic [7:0]  wreg = '0, rbyte;
  logic [21:0] tp = '0;

  always @(negedge clk) cyc++;

  always @(posedge pgc) if (rst_n) begin
    t_rise = cyc;
    if (bitn == 0 && n_frames > 0) chk(cyc - t_fall >= GAP, "R9 gap", cyc - t_fall, GAP);
    if (bitn == 12 && cmd == 4'b1001) chk(cyc - t_fall >= TURN, "R4 turnaround", cyc - t_fall, TURN);
    if (bitn >= 12 && cmd == 4'b1001) begin
      rbyte  = mem_byte(tp);
      pgd_in = rbyte[bitn - 12];
    end
  end

  always @(negedge pgc) if (rst_n) begin
    chk(cyc - t_rise == HALF, "R5 high phase", cyc - t_rise, HALF);
    if (bitn < 4) begin
      cmd[bitn] = pgd;
      chk(pgd_oe, "R2 code driven", pgd_oe, 1);
    end else if (bitn >= 12 && cmd == 4'b1001) begin
      chk(!pgd_oe, "R4 released", pgd_oe, 0);
    end else begin
      pay[bitn - 4] = pgd;
      chk(pgd_oe, "R2 operand driven", pgd_oe, 1);
    end
    bitn++;
    t_fall = cyc;
    if (bitn == 20) begin
      bitn = 0;
      n_frames++;
      pgd_in = 1'b1;
      if (cmd == 4'b0000) begin
        core_log[core_cnt % 6] = pay;
        core_cnt++;
        if (pay[15:8] == 8'h0E)   wreg = pay[7:0];
        else if (pay == 16'h6EF8) tp[21:16] = wreg[5:0];
        else if (pay == 16'h6EF7) tp[15:8]  = wreg;
        else if (pay == 16'h6EF6) tp[7:0]   = wreg;
      end else if (cmd == 4'b1001) begin
        chk(pay[7:0] == 8'h00, "R3 read operand", pay[7:0], 0);
        tp++;
        n_reads++;
      end else chk(0, "R2 command code", cmd, 0);
    end
  end

  task automatic send_req(input logic [21:0] a, input logic [15:0] n);
    req_addr = a; req_count = n; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R11 ready at reset", req_ready, 1);
    chk(!pgc && !pgd_oe, "R11 line quiet at reset", {pgc, pgd_oe}, 0);
    chk(!rsp_valid && !err, "R11 no rsp/err at reset", {rsp_valid, err}, 0);
  endtask

  task automatic t_read(input logic [21:0] a, input int n, input bit stall);
    int c0 = core_cnt, r0 = n_reads, nf;
    logic [7:0] d;
    logic [15:0] ew;
    rsp_ready = !stall;
    send_req(a, 16'(n));
    for (int i = 0; i < n; i++) begin
      while (!rsp_valid) @(negedge clk);
      chk(rsp_data == mem_byte(22'(a + i)), "R3 R6 byte", rsp_data, mem_byte(22'(a + i)));
      if (stall && i == 0) begin
        d = rsp_data; nf = n_frames;
        repeat (15) @(negedge clk);
        chk(rsp_valid && rsp_data == d, "R10 held byte", rsp_data, d);
        chk(n_frames == nf && !pgc, "R10 no frame while stalled", n_frames, nf);
        rsp_ready = 1'b1;
      end
      @(negedge clk);
    end
    while (!req_ready) @(negedge clk);
    chk(core_cnt - c0 == 6, "R6 one address load", core_cnt - c0, 6);
    chk(n_reads - r0 == n, "R6 read frame count", n_reads - r0, n);
    chk(tp == 22'(a + n), "R6 target pointer", tp, 22'(a + n));
    for (int k = 0; k < 6; k++) begin
      case (k)
        0: ew = {8'h0E, 2'b00, a[21:16]};
        1: ew = 16'h6EF8;
        2: ew = {8'h0E, a[15:8]};
        3: ew = 16'h6EF7;
        4: ew = {8'h0E, a[7:0]};
        default: ew = 16'h6EF6;
      endcase
      chk(core_log[k] == ew, "R1 load payload", core_log[k], ew);
    end
  endtask

  task automatic t_overrun(input logic [21:0] a, input logic [15:0] n);
    int nf = n_frames;
    send_req(a, n);
    chk(err == 1'b1, "R7 err pulse", err, 1);
    @(negedge clk);
    chk(err == 1'b0, "R7 err one cycle", err, 0);
    repeat (30) @(negedge clk);
    chk(n_frames == nf && !pgc, "R7 no clocking", n_frames, nf);
    chk(!rsp_valid && req_ready, "R7 no response", {rsp_valid, req_ready}, 1);
  endtask

  task automatic t_zero(input logic [21:0] a);
    int nf = n_frames;
    send_req(a, 16'd0);
    chk(err == 1'b0, "R8 no err", err, 0);
    repeat (30) @(negedge clk);
    chk(n_frames == nf && !rsp_valid && req_ready, "R8 no activity", n_frames, nf);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_read(22'h001234, 4, 1'b0);
    t_read(22'h300000, 3, 1'b1);
    t_read(22'h3FFFFE, 2, 1'b0);
    t_overrun(22'h3FFFFE, 16'd3);
    t_overrun(22'h3FFFFF, 16'd2);
    t_zero(22'h3FFFFF);
    t_read(22'h0000FF, 2, 1'b0);
    t_reset();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule